// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one character per request into an asynchronous serial frame on a single output line. A word is handed over through a valid/ready handshake. The block then drives a low start bit, the data bits, an optional parity bit and a high stop period, and goes back to an idle high line. Bit timing comes from an external oversample tick: one bit period is `OSR` ticks. Because time is counted in ticks, a stop period of one and a half bits can be timed exactly.

Run-time inputs choose the following:
- the character length, with a 9-bit override;
- the parity scheme;
- the stop length;
- the bit order;
- inversion of the data bits.

The block captures all of these at the moment it accepts a word. A channel selector sits between the frame generator, the external receive line and the line handed to a neighbouring receiver. It is used for echo and loopback testing.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line_o` is high and `in_ready_o` is high.
- R2: A word is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` then stays low until the final stop tick has been counted. A valid word offered while a frame is in progress is ignored.
- R3: The start bit is low. The start bit and every data and parity bit each last exactly `OSR` ticks. Timing advances only on cycles where `tick_i` is high.
- R4: The length code `cfg_size_i` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. When `cfg_nine_i` is high, 9 data bits are sent whatever the length code. Bits of `in_data_i` above the selected length are not sent.
- R5: `cfg_msb_first_i` = 0 sends bit 0 of the character first. A value of 1 sends the highest selected bit first.
- R6: The parity code `cfg_parity_i` works as follows:
  - 0: even parity, so the character bits plus the parity bit hold an even count of ones.
  - 1: odd parity.
  - 2: the parity bit is always 0.
  - 3: the parity bit is always 1.
  - 4 to 7: no parity bit is sent.
  Parity is computed over the selected character bits before any inversion.
- R7: The stop code `cfg_stop_i` sets a high stop period of `OSR` ticks for code 0, `OSR + OSR/2` ticks for code 1, and `2*OSR` ticks for codes 2 and 3.
- R8: When `cfg_invert_i` is high, only the data bits are driven inverted. The start bit, parity bit and stop period are not inverted.
- R9: Configuration and data are captured at acceptance. Changes to any `cfg_*` input during a frame do not alter that frame.
- R10: The channel code `cfg_chan_i` routes the lines as follows:
  - 0 (normal): `tx_line_o` is the frame and `rx_core_o` is `rx_line_i`.
  - 1 (echo): both outputs follow `rx_line_i`.
  - 2 (local loopback): `tx_line_o` is held high and `rx_core_o` is the frame.
  - 3 (remote loopback): `tx_line_o` follows `rx_line_i` and `rx_core_o` is held high.
- R11: The frame line changes only on a cycle with a tick or on the acceptance of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversample tick, `OSR` per bit period |
| in_valid_i | input | 1 | Word offered |
| in_data_i | input | 9 | Character to send, bit 0 is the least significant |
| in_ready_o | output | 1 | High while idle and able to accept |
| cfg_size_i | input | 2 | Character length code |
| cfg_nine_i | input | 1 | 9-bit override |
| cfg_parity_i | input | 3 | Parity code |
| cfg_stop_i | input | 2 | Stop length code |
| cfg_msb_first_i | input | 1 | Bit order |
| cfg_invert_i | input | 1 | Invert data bits |
| cfg_chan_i | input | 2 | Channel routing code |
| rx_line_i | input | 1 | External receive line |
| tx_line_o | output | 1 | Serial output line |
| rx_core_o | output | 1 | Line presented to the local receiver |

## Verification
On every cycle, the assertions check four things:
- acceptance drops ready and pulls the line low;
- ready falls only because of an offered word;
- the line is high whenever the block is idle;
- the line moves only on a tick or on acceptance.

They also keep the tick counter and the bit index inside their bounds. The exact waveform can be shown only by the bench scenarios. These scenarios compare the bit sequence for each length, order, parity and inversion combination, the stop durations including the half-bit case, and the routing of each channel mode. They also cover the fact that a mid-frame configuration change or a second offered word leaves the frame unchanged.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_e;

    localparam logic [2:0] PAR_EVEN  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_ZERO  = 3'd2;
    localparam logic [2:0] PAR_ONE   = 3'd3;

    localparam logic [1:0] STOP_ONE  = 2'd0;
    localparam logic [1:0] STOP_HALF = 2'd1;

endpackage

// File: rtl/sft_char_prep.sv
module sft_char_prep #(
    parameter  int DATA_W = 9,
    localparam int IDXW   = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDXW-1:0]   nbits_i,
    input  logic              msb_first_i,
    output logic [DATA_W-1:0] word_o,
    output logic              par_raw_o
);

    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] reversed;

    // keep only the selected character bits
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign masked[gi] = data_i[gi] & (IDXW'(gi) < nbits_i);
    end

    // reverse within the selected length; positions past the length stay zero
    always_comb begin
        reversed = '0;
        for (int i = 0; i < DATA_W; i++) begin
            for (int j = 0; j < DATA_W; j++) begin
                if (IDXW'(j) == nbits_i - IDXW'(1) - IDXW'(i)) begin
                    reversed[i] = reversed[i] | masked[j];
                end
            end
        end
    end

    assign word_o    = msb_first_i ? reversed : masked;
    assign par_raw_o = ^masked;

endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
    import sft_pkg::*;
#(
    parameter  int DATA_W = 9,
    parameter  int OSR    = 16,
    localparam int IDXW   = $clog2(DATA_W + 1),
    localparam int CW     = $clog2(2 * OSR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              par_raw_i,
    input  logic [IDXW-1:0]   nbits_i,
    input  logic [2:0]        par_mode_i,
    input  logic [1:0]        stop_mode_i,
    input  logic              invert_i,
    output logic              ready_o,
    output logic              line_o
);

    localparam logic [CW-1:0] BIT_LEN  = CW'(OSR);
    localparam logic [CW-1:0] HALF_LEN = CW'(OSR + OSR / 2);
    localparam logic [CW-1:0] TWO_LEN  = CW'(2 * OSR);

    typedef struct packed {
        tx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [IDXW-1:0]   idx;
        logic [DATA_W-1:0] sh;
        logic [IDXW-1:0]   nbits;
        logic              has_par;
        logic              par_bit;
        logic [CW-1:0]     stop_len;
        logic              inv;
        logic              line;
    } seq_t;

    seq_t          seq_q, seq_d;
    logic [CW-1:0] lim;
    logic          last_tick;

    always_comb begin
        seq_d     = seq_q;
        lim       = (seq_q.st == ST_STOP) ? seq_q.stop_len : BIT_LEN;
        last_tick = tick_i && (seq_q.cnt == lim - CW'(1));
        if (seq_q.st == ST_IDLE) begin
            seq_d.line = 1'b1;
            if (valid_i) begin
                seq_d.st    = ST_START;
                seq_d.cnt   = '0;
                seq_d.idx   = '0;
                seq_d.sh    = word_i;
                seq_d.nbits = nbits_i;
                seq_d.inv   = invert_i;
                seq_d.line  = 1'b0;
                case (par_mode_i)
                    PAR_EVEN: begin seq_d.has_par = 1'b1; seq_d.par_bit = par_raw_i;  end
                    PAR_ODD:  begin seq_d.has_par = 1'b1; seq_d.par_bit = ~par_raw_i; end
                    PAR_ZERO: begin seq_d.has_par = 1'b1; seq_d.par_bit = 1'b0;       end
                    PAR_ONE:  begin seq_d.has_par = 1'b1; seq_d.par_bit = 1'b1;       end
                    default:  begin seq_d.has_par = 1'b0; seq_d.par_bit = 1'b0;       end
                endcase
                case (stop_mode_i)
                    STOP_ONE:  seq_d.stop_len = BIT_LEN;
                    STOP_HALF: seq_d.stop_len = HALF_LEN;
                    default:   seq_d.stop_len = TWO_LEN;
                endcase
            end
        end else if (tick_i) begin
            if (last_tick) begin
                seq_d.cnt = '0;
                case (seq_q.st)
                    ST_START: begin
                        seq_d.st   = ST_DATA;
                        seq_d.line = seq_q.sh[0] ^ seq_q.inv;
                    end
                    ST_DATA: begin
                        if (seq_q.idx == seq_q.nbits - IDXW'(1)) begin
                            if (seq_q.has_par) begin
                                seq_d.st   = ST_PARITY;
                                seq_d.line = seq_q.par_bit;
                            end else begin
                                seq_d.st   = ST_STOP;
                                seq_d.line = 1'b1;
                            end
                        end else begin
                            seq_d.idx  = seq_q.idx + IDXW'(1);
                            seq_d.sh   = seq_q.sh >> 1;
                            seq_d.line = seq_q.sh[1] ^ seq_q.inv;
                        end
                    end
                    ST_PARITY: begin
                        seq_d.st   = ST_STOP;
                        seq_d.line = 1'b1;
                    end
                    default: begin
                        seq_d.st   = ST_IDLE;
                        seq_d.line = 1'b1;
                    end
                endcase
            end else begin
                seq_d.cnt = seq_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.line <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready_o = (seq_q.st == ST_IDLE);
    assign line_o  = seq_q.line;

    // R2: taking a word closes the handshake and opens the start bit
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> (!ready_o && !line_o));

    // R2: ready can only fall because a word was offered
    a_r2_ready_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(valid_i));

    // R1: idle means a high line
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> line_o);

    // R11: the line holds on cycles without tick or acceptance
    a_r11_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(valid_i && ready_o)) |=> $stable(line_o));

    // R3: tick counter stays below the longest period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt < TWO_LEN);

    // R4: bit index never passes the captured length
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DATA) |-> (seq_q.idx < seq_q.nbits));

endmodule

// File: rtl/sft_line_route.sv
module sft_line_route
    import sft_pkg::*;
(
    input  logic [1:0] chan_i,
    input  logic       frame_line_i,
    input  logic       rx_line_i,
    output logic       tx_line_o,
    output logic       rx_core_o
);

    always_comb begin
        case (chan_e'(chan_i))
            CH_ECHO: begin
                tx_line_o = rx_line_i;
                rx_core_o = rx_line_i;
            end
            CH_LOCAL: begin
                tx_line_o = 1'b1;
                rx_core_o = frame_line_i;
            end
            CH_REMOTE: begin
                tx_line_o = rx_line_i;
                rx_core_o = 1'b1;
            end
            default: begin
                tx_line_o = frame_line_i;
                rx_core_o = rx_line_i;
            end
        endcase
    end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter  int DATA_W = 9,
    parameter  int OSR    = 16,
    localparam int IDXW   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    input  logic [1:0]        cfg_size_i,
    input  logic              cfg_nine_i,
    input  logic [2:0]        cfg_parity_i,
    input  logic [1:0]        cfg_stop_i,
    input  logic              cfg_msb_first_i,
    input  logic              cfg_invert_i,
    input  logic [1:0]        cfg_chan_i,
    input  logic              rx_line_i,
    output logic              tx_line_o,
    output logic              rx_core_o
);

    logic [IDXW-1:0]   nbits;
    logic [DATA_W-1:0] word;
    logic              par_raw;
    logic              frame_line;

    // the wide override outranks the length code
    assign nbits = cfg_nine_i ? IDXW'(DATA_W) : (IDXW'(5) + IDXW'(cfg_size_i));

    sft_char_prep #(.DATA_W(DATA_W)) u_prep (
        .data_i      (in_data_i),
        .nbits_i     (nbits),
        .msb_first_i (cfg_msb_first_i),
        .word_o      (word),
        .par_raw_o   (par_raw)
    );

    sft_sequencer #(.DATA_W(DATA_W), .OSR(OSR)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .valid_i     (in_valid_i),
        .word_i      (word),
        .par_raw_i   (par_raw),
        .nbits_i     (nbits),
        .par_mode_i  (cfg_parity_i),
        .stop_mode_i (cfg_stop_i),
        .invert_i    (cfg_invert_i),
        .ready_o     (in_ready_o),
        .line_o      (frame_line)
    );

    sft_line_route u_route (
        .chan_i       (cfg_chan_i),
        .frame_line_i (frame_line),
        .rx_line_i    (rx_line_i),
        .tx_line_o    (tx_line_o),
        .rx_core_o    (rx_core_o)
    );

endmodule

// File: tb/serial_frame_tx_tb.sv
`timescale 1ns/1ps
module serial_frame_tx_tb;

    localparam int OSR = 16;
    localparam int CAP = 640;
    localparam int NV  = 8;

    typedef struct packed {
        logic [8:0] data;
        logic [1:0] size;
        logic       nine;
        logic [2:0] par;
        logic [1:0] stop;
        logic       msb;
        logic       inv;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{9'h0A5, 2'd3, 1'b0, 3'd4, 2'd0, 1'b0, 1'b0},
        '{9'h1FB, 2'd0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0},
        '{9'h035, 2'd1, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0},
        '{9'h04C, 2'd2, 1'b0, 3'd2, 2'd2, 1'b1, 1'b0},
        '{9'h1C3, 2'd0, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0},
        '{9'h0C6, 2'd3, 1'b0, 3'd0, 2'd1, 1'b0, 1'b1},
        '{9'h00F, 2'd3, 1'b0, 3'd1, 2'd2, 1'b1, 1'b1},
        '{9'h1FF, 2'd2, 1'b1, 3'd0, 2'd3, 1'b1, 1'b0}
    };
    string tags [NV] = '{"R4", "R6", "R7", "R5", "R4", "R8", "R5", "R7"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_ready;
    logic [1:0] cfg_size = 2'd3;
    logic       cfg_nine = 1'b0;
    logic [2:0] cfg_parity = 3'd4;
    logic [1:0] cfg_stop = 2'd0;
    logic       cfg_msb = 1'b0;
    logic       cfg_inv = 1'b0;
    logic [1:0] cfg_chan = 2'd0;
    logic       rx_line = 1'b1;
    logic       tx_line;
    logic       rx_core;

    int   checks = 0;
    int   fails  = 0;
    logic cap  [CAP];
    logic expw [CAP];
    int   cap_len;
    int   exp_len;
    bit   saw_tx_low;

    always #10 clk = ~clk;

    serial_frame_tx #(.DATA_W(9), .OSR(OSR)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick),
        .in_valid_i      (in_valid),
        .in_data_i       (in_data),
        .in_ready_o      (in_ready),
        .cfg_size_i      (cfg_size),
        .cfg_nine_i      (cfg_nine),
        .cfg_parity_i    (cfg_parity),
        .cfg_stop_i      (cfg_stop),
        .cfg_msb_first_i (cfg_msb),
        .cfg_invert_i    (cfg_inv),
        .cfg_chan_i      (cfg_chan),
        .rx_line_i       (rx_line),
        .tx_line_o       (tx_line),
        .rx_core_o       (rx_core)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic put_bits(input logic val, input int n);
        for (int k = 0; k < n; k++) begin
            expw[exp_len] = val;
            exp_len++;
        end
    endtask

    // expected per-cycle waveform with a tick on every cycle
    task automatic build_exp(input vec_t v);
        int   n;
        logic p;
        n = v.nine ? 9 : 5 + int'(v.size);
        p = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ v.data[i];
        exp_len = 0;
        put_bits(1'b0, OSR);
        for (int i = 0; i < n; i++) begin
            put_bits((v.msb ? v.data[n-1-i] : v.data[i]) ^ v.inv, OSR);
        end
        case (v.par)
            3'd0: put_bits(p, OSR);
            3'd1: put_bits(~p, OSR);
            3'd2: put_bits(1'b0, OSR);
            3'd3: put_bits(1'b1, OSR);
            default: ;
        endcase
        case (v.stop)
            2'd0: put_bits(1'b1, OSR);
            2'd1: put_bits(1'b1, OSR + OSR / 2);
            default: put_bits(1'b1, 2 * OSR);
        endcase
    endtask

    task automatic apply_cfg(input vec_t v);
        cfg_size   = v.size;
        cfg_nine   = v.nine;
        cfg_parity = v.par;
        cfg_stop   = v.stop;
        cfg_msb    = v.msb;
        cfg_inv    = v.inv;
        in_data    = v.data;
    endtask

    // entered and left at a falling edge
    task automatic capture(input bit watch_core, input bit poke, input vec_t v);
        cap_len    = 0;
        saw_tx_low = 1'b0;
        while (!in_ready && cap_len < CAP) begin
            cap[cap_len] = watch_core ? rx_core : tx_line;
            if (!tx_line) saw_tx_low = 1'b1;
            if (poke && cap_len == 10) begin
                in_valid   = 1'b1;
                in_data    = ~v.data;
                cfg_size   = ~v.size;
                cfg_parity = 3'd3;
                cfg_stop   = ~v.stop;
                cfg_inv    = ~v.inv;
                cfg_msb    = ~v.msb;
            end
            if (poke && cap_len == 50) in_valid = 1'b0;
            cap_len++;
            @(negedge clk);
        end
    endtask

    task automatic send(input vec_t v);
        apply_cfg(v);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic compare(input string req, input string what);
        int bad;
        bad = -1;
        for (int i = 0; i < exp_len && i < cap_len; i++) begin
            if (bad < 0 && cap[i] !== expw[i]) bad = i;
        end
        check(cap_len == exp_len, req, {what, " frame cycles"}, cap_len, exp_len);
        if (bad >= 0)
            check(1'b0, req, {what, " line at cycle"}, int'(cap[bad]), int'(expw[bad]));
        else
            check(1'b1, req, {what, " waveform"}, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int hold_bad;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_line == 1'b1, "R1", "reset tx line", int'(tx_line), 1);
        check(in_ready == 1'b1, "R1", "reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b1 && in_ready == 1'b1, "R1", "idle after reset", int'({tx_line, in_ready}), 3);

        // table of frames
        for (int vi = 0; vi < NV; vi++) begin
            build_exp(VECS[vi]);
            send(VECS[vi]);
            capture(1'b0, 1'b0, VECS[vi]);
            compare(tags[vi], $sformatf("vector %0d", vi));
        end

        // R3: no ticks means the start bit is held
        tick = 1'b0;
        build_exp(VECS[0]);
        send(VECS[0]);
        hold_bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (tx_line !== 1'b0 || in_ready !== 1'b0) hold_bad++;
            @(negedge clk);
        end
        check(hold_bad == 0, "R3", "start held without tick", hold_bad, 0);
        tick = 1'b1;
        capture(1'b0, 1'b0, VECS[0]);
        compare("R3", "after tick resume");

        // R2 and R9: second word and config changes during a frame
        build_exp(VECS[5]);
        send(VECS[5]);
        capture(1'b0, 1'b1, VECS[5]);
        compare("R9", "mid-frame config change");
        hold_bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (tx_line !== 1'b1 || in_ready !== 1'b1) hold_bad++;
            @(negedge clk);
        end
        check(hold_bad == 0, "R2", "busy-time word ignored", hold_bad, 0);

        // R10: channel routing
        cfg_chan = 2'd0;
        rx_line  = 1'b0;
        #1;
        check(rx_core == 1'b0 && tx_line == 1'b1, "R10", "normal routing", int'({tx_line, rx_core}), 2);
        cfg_chan = 2'd1;
        #1;
        check(tx_line == 1'b0 && rx_core == 1'b0, "R10", "echo low", int'({tx_line, rx_core}), 0);
        rx_line = 1'b1;
        #1;
        check(tx_line == 1'b1 && rx_core == 1'b1, "R10", "echo high", int'({tx_line, rx_core}), 3);
        cfg_chan = 2'd3;
        rx_line  = 1'b0;
        #1;
        check(tx_line == 1'b0 && rx_core == 1'b1, "R10", "remote loopback", int'({tx_line, rx_core}), 1);
        rx_line = 1'b1;
        cfg_chan = 2'd2;
        @(negedge clk);
        build_exp(VECS[2]);
        send(VECS[2]);
        capture(1'b1, 1'b0, VECS[2]);
        compare("R10", "local loopback frame");
        check(!saw_tx_low, "R10", "local loopback tx held high", int'(saw_tx_low), 0);
        cfg_chan = 2'd0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule